// File: doc/BRIEF.md
# Equalizer Boost Serial Loader

This block takes the boost settings for a four-channel equalizer over a three-wire serial link: a data line, an active-low load window and a serial clock. While the window is open (enable low), each rising edge of the serial clock pushes one bit into a 21-stage chain. When enable rises, the chain is copied into a holding register. Only the holding register drives the outputs. Bits sent into an open window therefore have no effect on the equalizer until the window closes.

The lowest position of the latched word is an override flag. The remaining twenty positions are four 5-bit boost codes, one for each channel. While the flag is set, every channel takes its code from the latched word. While the flag is clear, every channel takes the code on its external pin bus.

The three serial lines are sampled on the block clock. They are assumed to be already synchronous to that clock and slow compared with it. The serial link is a plain control interface. It has no valid/ready handshake and no back-pressure: every qualified edge is accepted.

Top module: `eq_boost_loader`

## Requirements
- R1: After synchronous reset, the chain and the holding register are zero. The override output is 0 and every boost output equals its pin code. A window closed with no bits sent after reset latches all zeros.
- R2: The chain moves by one position only on a rising edge of the serial clock seen while enable is low. Falling edges, and rising edges while enable is high, leave the chain unchanged.
- R3: While enable is low, the override output and all boost outputs hold their values, whatever is shifted in.
- R4: On each rising edge of enable, the holding register takes the chain contents exactly once. The outputs show the new value one block-clock cycle after the edge is sampled, and they stay put while enable remains high.
- R5: Bit order: each new bit enters word position 0, and older bits move toward position 20. Of 21 bits sent, the first sent lands in position 20 and the last sent lands in position 0 (the override flag).
- R6: When more than 21 bits are sent in one window, only the 21 most recent are kept.
- R7: When fewer than 21 bits are sent, the older chain contents move up by that many positions and are latched as they are, with no padding and no error flag.
- R8: With the override flag at 1, channel c (c = 0..3) outputs word positions 1+5c (LSB) through 5+5c (MSB). Changes on the pins then have no effect on the boost outputs.
- R9: With the override flag at 0, boost output c equals pin bus bits [5c+4:5c] and follows pin changes with no clock delay.
- R10: The override output equals position 0 of the latched word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock, sampled on clk |
| sdata_i | input | 1 | Serial data, taken on a serial-clock rising edge |
| sen_n_i | input | 1 | Load window, active low; its rising edge latches the word |
| pin_boost_i | input | NUM_CH*CODE_W | Pin-set boost codes, channel c at bits [CODE_W*c +: CODE_W] |
| boost_o | output | NUM_CH*CODE_W | Effective boost codes, same packing as the pins |
| ovr_o | output | 1 | Latched override flag |

## Verification
Assertions check four things on every cycle. The holding register does not move while enable is low or stays high. It takes the chain exactly on an enable rise. The chain moves by exactly one position, only on a qualified serial-clock edge. The pins pass straight through whenever the override is off. Bit order, window overruns, short windows, the field positions of each channel's code and the zero state after reset can only be shown by the bench. It drives whole serial sequences and compares the latched result against a model of the chain built from the requirements.

// File: rtl/eqld_pkg.sv
package eqld_pkg;
  localparam int DEF_NUM_CH = 4;
  localparam int DEF_CODE_W = 5;

  // override flag occupies one position below the packed codes
  function automatic int chain_len(input int num_ch, input int code_w);
    return 1 + num_ch * code_w;
  endfunction
endpackage

// File: rtl/eqld_edge_det.sv
module eqld_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  // reset high so a line already high at reset release gives no edge
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b1;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/eqld_shift_chain.sv
module eqld_shift_chain #(
  parameter int LEN = 21
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_i,
  input  logic           bit_i,
  output logic [LEN-1:0] word_o
);
  logic [LEN-1:0] chain_q;

  // newest bit at position 0, oldest falls off the top
  always_ff @(posedge clk) begin
    if (rst)         chain_q <= '0;
    else if (step_i) chain_q <= {chain_q[LEN-2:0], bit_i};
  end

  assign word_o = chain_q;
endmodule

// File: rtl/eqld_hold_reg.sv
module eqld_hold_reg #(
  parameter int LEN = 21
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [LEN-1:0] word_i,
  output logic [LEN-1:0] word_o
);
  logic [LEN-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= '0;
    else if (load_i) hold_q <= word_i;
  end

  assign word_o = hold_q;
endmodule

// File: rtl/eqld_boost_sel.sv
module eqld_boost_sel #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 5
) (
  input  logic [NUM_CH*CODE_W:0]   word_i,
  input  logic [NUM_CH*CODE_W-1:0] pin_i,
  output logic [NUM_CH*CODE_W-1:0] boost_o,
  output logic                     ovr_o
);
  localparam int FIELD_BASE = 1;

  assign ovr_o = word_i[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] reg_code;
    logic [CODE_W-1:0] pin_code;
    assign reg_code = word_i[FIELD_BASE + c*CODE_W +: CODE_W];
    assign pin_code = pin_i[c*CODE_W +: CODE_W];
    assign boost_o[c*CODE_W +: CODE_W] = ovr_o ? reg_code : pin_code;
  end
endmodule

// File: rtl/eq_boost_loader.sv
module eq_boost_loader
  import eqld_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int CODE_W = DEF_CODE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclk_i,
  input  logic                     sdata_i,
  input  logic                     sen_n_i,
  input  logic [NUM_CH*CODE_W-1:0] pin_boost_i,
  output logic [NUM_CH*CODE_W-1:0] boost_o,
  output logic                     ovr_o
);
  localparam int CHAIN_LEN = chain_len(NUM_CH, CODE_W);

  logic                 sclk_rise;
  logic                 sen_rise;
  logic                 shift_step;
  logic [CHAIN_LEN-1:0] shift_w;
  logic [CHAIN_LEN-1:0] hold_w;

  eqld_edge_det i_sclk_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sclk_i),
    .rise_o (sclk_rise)
  );

  eqld_edge_det i_sen_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sen_n_i),
    .rise_o (sen_rise)
  );

  assign shift_step = sclk_rise & ~sen_n_i;

  eqld_shift_chain #(.LEN(CHAIN_LEN)) i_chain (
    .clk    (clk),
    .rst    (rst),
    .step_i (shift_step),
    .bit_i  (sdata_i),
    .word_o (shift_w)
  );

  eqld_hold_reg #(.LEN(CHAIN_LEN)) i_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (sen_rise),
    .word_i (shift_w),
    .word_o (hold_w)
  );

  eqld_boost_sel #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_sel (
    .word_i  (hold_w),
    .pin_i   (pin_boost_i),
    .boost_o (boost_o),
    .ovr_o   (ovr_o)
  );
endmodule

// File: rtl/eqld_checker.sv
module eqld_checker #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sclk_i,
  input logic                     sdata_i,
  input logic                     sen_n_i,
  input logic [NUM_CH*CODE_W-1:0] pin_boost_i,
  input logic [NUM_CH*CODE_W-1:0] boost_o,
  input logic                     ovr_o,
  input logic [NUM_CH*CODE_W:0]   shift_w,
  input logic [NUM_CH*CODE_W:0]   hold_w
);
  localparam int LEN = NUM_CH*CODE_W + 1;

  logic sen_prev;
  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sen_prev  <= 1'b1;
      sclk_prev <= 1'b1;
    end else begin
      sen_prev  <= sen_n_i;
      sclk_prev <= sclk_i;
    end
  end

  // R3
  hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !sen_n_i |=> $stable(hold_w));

  // R4
  hold_take_chk: assert property (@(posedge clk) disable iff (rst)
    (sen_n_i && !sen_prev) |=> (hold_w == $past(shift_w)));

  // R4
  hold_once_chk: assert property (@(posedge clk) disable iff (rst)
    (sen_n_i && sen_prev) |=> $stable(hold_w));

  // R2
  chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(sclk_i && !sclk_prev && !sen_n_i) |=> $stable(shift_w));

  // R5
  chain_step_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_i && !sclk_prev && !sen_n_i) |=>
      (shift_w == {$past(shift_w[LEN-2:0]), $past(sdata_i)}));

  // R9
  pin_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !ovr_o |-> (boost_o == pin_boost_i));
endmodule

bind eq_boost_loader eqld_checker #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .sclk_i      (sclk_i),
  .sdata_i     (sdata_i),
  .sen_n_i     (sen_n_i),
  .pin_boost_i (pin_boost_i),
  .boost_o     (boost_o),
  .ovr_o       (ovr_o),
  .shift_w     (shift_w),
  .hold_w      (hold_w)
);

// File: tb/test_eq_boost_loader.sv
module test_eq_boost_loader;
  localparam int PERIOD = 10;
  localparam int QTR    = PERIOD / 4;
  localparam int NCH    = 4;
  localparam int CW     = 5;
  localparam int BW     = NCH * CW;
  localparam int LEN    = BW + 1;

  logic          clk   = 1'b0;
  logic          rst   = 1'b1;
  logic          sclk  = 1'b0;
  logic          sdata = 1'b0;
  logic          sen_n = 1'b1;
  logic [BW-1:0] pins  = 20'h5A3C9;
  logic [BW-1:0] boost;
  logic          ovr;

  logic [LEN-1:0] model_chain = '0;
  logic [LEN-1:0] exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit sen_last = 1'b1;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  eq_boost_loader i_eq_boost_loader (
    .clk         (clk),
    .rst         (rst),
    .sclk_i      (sclk),
    .sdata_i     (sdata),
    .sen_n_i     (sen_n),
    .pin_boost_i (pins),
    .boost_o     (boost),
    .ovr_o       (ovr)
  );

  function automatic logic [BW-1:0] exp_boost(input logic [LEN-1:0] w, input logic [BW-1:0] p);
    logic [BW-1:0] r;
    for (int c = 0; c < NCH; c++)
      r[c*CW +: CW] = w[0] ? w[1 + c*CW +: CW] : p[c*CW +: CW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: on each latch, pop the expected word and compare the outputs
  initial begin
    forever begin
      @(posedge clk);
      #(QTR);
      if (!rst && sen_n && !sen_last) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected latch", 32'(ovr), 32'd0);
        end else begin
          logic [LEN-1:0] w;
          w = exp_q.pop_front();
          chk(ovr == w[0], "R10 override output", 32'(ovr), 32'(w[0]));
          chk(boost == exp_boost(w, pins), "R4 R8 latched boost", 32'(boost), 32'(exp_boost(w, pins)));
        end
      end
      sen_last = sen_n;
    end
  end

  task automatic open_win();
    @(negedge clk); sen_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    if (!sen_n) model_chain = {model_chain[LEN-2:0], b};
  endtask

  task automatic close_win();
    @(negedge clk);
    exp_q.push_back(model_chain);
    sen_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // send n bits, highest position first; R3 checked after every bit
  task automatic send_word(input logic [31:0] w, input int n);
    logic [BW-1:0] b0;
    logic          o0;
    b0 = boost;
    o0 = ovr;
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(w[i]);
      chk(boost == b0 && ovr == o0, "R3 outputs frozen in window", 32'(boost), 32'(b0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      wrap_up();
    end
  end

  initial begin
    logic [LEN-1:0] w1;
    logic [LEN-1:0] w2;
    logic [BW-1:0]  b_keep;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ovr == 1'b0, "R1 override after reset", 32'(ovr), 32'd0);
    chk(boost == pins, "R1 boost equals pins after reset", 32'(boost), 32'(pins));
    open_win();
    close_win();   // R1 empty window latches zero chain

    // R5 R8: ch1=13 ch2=05 ch3=1E ch4=0A, override on
    w1 = {5'h0A, 5'h1E, 5'h05, 5'h13, 1'b1};
    open_win();
    send_word(32'(w1), LEN);
    close_win();
    chk(boost[4:0] == 5'h13, "R5 channel 0 field", 32'(boost[4:0]), 32'h13);
    chk(boost[19:15] == 5'h0A, "R5 channel 3 field", 32'(boost[19:15]), 32'h0A);
    pins = 20'hF0F0F;
    @(negedge clk);
    chk(boost == 20'(w1 >> 1), "R8 pins ignored with override", 32'(boost), 32'(w1 >> 1));

    // R6: 4 leading junk bits then a word with override off
    w2 = {5'h11, 5'h02, 5'h1F, 5'h08, 1'b0};
    open_win();
    send_word(32'hF, 4);
    send_word(32'(w2), LEN);
    close_win();
    chk(ovr == 1'b0, "R6 last 21 bits kept", 32'(ovr), 32'd0);
    pins = 20'h12345;
    #1;
    chk(boost == 20'h12345, "R9 boost follows pins", 32'(boost), 32'h12345);

    // R7: short window of 7 bits
    open_win();
    send_word(32'b1010011, 7);
    close_win();

    // R2: serial clock pulses with enable high do not shift
    repeat (5) send_bit(1'b1);
    open_win();
    close_win();

    // R4: latched value holds while enable stays high
    b_keep = boost;
    repeat (20) @(negedge clk);
    chk(boost == b_keep, "R4 no reload while enable high", 32'(boost), 32'(b_keep));

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 every window latched", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    wrap_up();
  end
endmodule